// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides when a processor core is halted in a low-power sleep state and when it resumes. It watches decoded strobes from the core for the wait-for-interrupt, wait-for-event and send-event instructions, plus a strobe marking an exception return into thread mode. It also sees the pending, enable and priority state of every interrupt line, the core's current execution priority and a global interrupt mask bit. From these it drives a halt signal, a one-cycle wake strobe, an acknowledge meaning a wait-for-event completed without sleeping, and a permission to take an exception.

The wake rule depends on how sleep was entered. A one-hot state machine records the entry path. Sleep entered through wait-for-interrupt, or through the automatic sleep-on-exit path, ends only when an enabled interrupt of strictly higher priority is pending. Sleep entered through wait-for-event also ends on a hidden one-bit event flag. Software cannot read or write this flag. The send-event strobe sets it. A rising pending edge on any interrupt line sets it too, when the event-on-new-pending control bit is on.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After synchronous reset, `core_halt`, `wake_stb`, `wfe_skip_ack` and `exc_take_ok` are 0 and the event flag is clear, so the first wait-for-event enters sleep.
- R2: A `wfi_stb` cycle with no eligible interrupt drives `core_halt` high from the next cycle.
- R3: A `wfi_stb` cycle in which an eligible interrupt is already pending leaves `core_halt` low.
- R4: With the event flag clear, `wfe_stb` enters sleep. With the flag set, `wfe_skip_ack` is 1 in the strobe cycle, the core stays awake, and the flag is cleared, so the next `wfe_stb` sleeps.
- R5: `sev_stb` sets the event flag. During wait-for-event sleep, `sev_stb` wakes the core.
- R6: `exc_ret_stb` enters sleep only while `sleep_on_exit_en` is 1.
- R7: Sleep entered by wait-for-interrupt or sleep-on-exit ends only on an interrupt that is pending, enabled, and has a priority value strictly below `cur_prio`. The priority of line k is `irq_prio[k*PRIO_W +: PRIO_W]`, and a lower value means higher priority. Disabled lines, equal priority and new-pending events do not wake it.
- R8: `exc_take_ok` is 1 exactly when an eligible interrupt is pending and `int_mask` is 0. A wake that happens with the mask set does not permit handler entry until the mask clears.
- R9: Sleep entered by wait-for-event ends on an eligible interrupt.
- R10: While `evt_on_pend_en` is 1, a 0-to-1 change of any `irq_pend` bit sets the event flag and wakes wait-for-event sleep, even if that line is disabled. A bit that stays high does not set the flag again. While `evt_on_pend_en` is 0, no such event is raised.
- R11: `wake_stb` is high for exactly one cycle on each exit from sleep, in the last sleeping cycle. `core_halt` is low from the next cycle.
- R12: While sleeping, `wfi_stb`, `wfe_stb` and `exc_ret_stb` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_stb | input | 1 | Decoded wait-for-interrupt strobe |
| wfe_stb | input | 1 | Decoded wait-for-event strobe |
| sev_stb | input | 1 | Decoded send-event strobe |
| exc_ret_stb | input | 1 | Return from last handler to thread mode |
| irq_pend | input | NUM_IRQ | Per-line pending bits |
| irq_en | input | NUM_IRQ | Per-line enable bits |
| irq_prio | input | NUM_IRQ*PRIO_W | Packed per-line priority values |
| cur_prio | input | PRIO_W | Current execution priority |
| int_mask | input | 1 | Global interrupt mask |
| sleep_on_exit_en | input | 1 | Sleep when returning to thread mode |
| evt_on_pend_en | input | 1 | New pending interrupt raises an event |
| core_halt | output | 1 | Core is held in sleep |
| wfe_skip_ack | output | 1 | Wait-for-event finished without sleeping |
| wake_stb | output | 1 | One-cycle wake pulse |
| exc_take_ok | output | 1 | Core may enter an exception handler |

## Verification
The bench targets the cases where the entry path changes the wake rule. A disabled line, an equal-priority line, or a new-pending event must leave wait-for-interrupt and sleep-on-exit sleep untouched. A design that merged the wake rules would release the core early. The event flag is also tested: a flag set during other sleep must make the next wait-for-event skip, a skip must clear the flag, and a held pending bit must not re-raise it. A missed clear would make every later wait-for-event fall through. A missed edge detection would keep waking the core. Further cases cover a strobe in the same cycle as an eligible interrupt, strobes arriving during sleep, and a wake under the global mask. Faults there show up as a halt that is never released, a re-entry into sleep, or a handler taken while masked.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;

    typedef enum logic [3:0] {
        ST_RUN  = 4'b0001,
        ST_WFI  = 4'b0010,
        ST_WFE  = 4'b0100,
        ST_EXIT = 4'b1000
    } slp_state_e;

    // core requests seen by the state machine (exit already qualified)
    typedef struct packed {
        logic wfi;
        logic wfe;
        logic exit_sleep;
    } core_req_t;

    // interrupt summary for the rest of the block
    typedef struct packed {
        logic eligible;
        logic new_pend;
    } irq_sum_t;

    // wake rule shared by the interrupt-only sleep paths
    function automatic logic irq_only_wake(input slp_state_e s);
        return (s == ST_WFI) || (s == ST_EXIT);
    endfunction

    function automatic logic is_sleeping(input slp_state_e s);
        return s != ST_RUN;
    endfunction

endpackage

// File: rtl/slpwk_irq_eval.sv
module slpwk_irq_eval
    import slpwk_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]         cur_prio,
    output irq_sum_t                  sum
);

    logic [NUM_IRQ-1:0] elig_vec;
    logic [NUM_IRQ-1:0] rise_vec;
    logic [NUM_IRQ-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= irq_pend;
    end

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
        logic [PRIO_W-1:0] line_prio;
        assign line_prio   = irq_prio[k*PRIO_W +: PRIO_W];
        assign elig_vec[k] = irq_pend[k] & irq_en[k] & (line_prio < cur_prio);
        assign rise_vec[k] = irq_pend[k] & ~pend_q[k];
    end

    assign sum.eligible = |elig_vec;
    assign sum.new_pend = |rise_vec;

    AST_HELD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(irq_pend)) |-> !sum.new_pend); // R10

endmodule

// File: rtl/slpwk_event_latch.sv
module slpwk_event_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic consume_i,
    input  logic wake_clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (wake_clr_i)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (consume_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (consume_i && !set_i) |=> !flag_o); // R4
    AST_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (set_i && !wake_clr_i) |=> flag_o); // R5

endmodule

// File: rtl/slpwk_fsm.sv
module slpwk_fsm
    import slpwk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  core_req_t  req,
    input  logic       irq_wake_i,
    input  logic       evt_wake_i,
    input  logic       flag_i,
    output logic       halt_o,
    output logic       wake_o,
    output logic       skip_o,
    output logic       consume_o,
    output logic       wfe_clr_o
);

    slp_state_e state_q, state_d;
    logic       wake_now;

    always_comb begin
        wake_now = 1'b0;
        if (irq_only_wake(state_q))
            wake_now = irq_wake_i;
        else if (state_q == ST_WFE)
            wake_now = irq_wake_i | evt_wake_i | flag_i;
    end

    always_comb begin
        state_d = state_q;
        if (!is_sleeping(state_q)) begin
            if (req.wfi)
                state_d = irq_wake_i ? ST_RUN : ST_WFI;
            else if (req.wfe)
                state_d = flag_i ? ST_RUN : ST_WFE;
            else if (req.exit_sleep)
                state_d = irq_wake_i ? ST_RUN : ST_EXIT;
        end else if (wake_now) begin
            state_d = ST_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    assign skip_o    = (state_q == ST_RUN) && !req.wfi && req.wfe && flag_i;
    assign consume_o = skip_o;
    assign wfe_clr_o = (state_q == ST_WFE) && wake_now;
    assign halt_o    = is_sleeping(state_q);
    assign wake_o    = is_sleeping(state_q) && wake_now;

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1); // R11
    AST_WFI_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && req.wfi && !irq_wake_i) |=> state_q == ST_WFI); // R2
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o); // R11
    AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> state_q == ST_RUN); // R11
    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (is_sleeping(state_q) && !wake_o) |=> $stable(state_q)); // R12

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import slpwk_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wfi_stb,
    input  logic                      wfe_stb,
    input  logic                      sev_stb,
    input  logic                      exc_ret_stb,
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]         cur_prio,
    input  logic                      int_mask,
    input  logic                      sleep_on_exit_en,
    input  logic                      evt_on_pend_en,
    output logic                      core_halt,
    output logic                      wfe_skip_ack,
    output logic                      wake_stb,
    output logic                      exc_take_ok
);

    irq_sum_t  isum;
    core_req_t req;
    logic      evt_set, flag, consume, wfe_clr;

    slpwk_irq_eval #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_eval (
        .clk      (clk),
        .rst      (rst),
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .irq_prio (irq_prio),
        .cur_prio (cur_prio),
        .sum      (isum)
    );

    assign evt_set = sev_stb | (evt_on_pend_en & isum.new_pend);

    slpwk_event_latch u_flag (
        .clk        (clk),
        .rst        (rst),
        .set_i      (evt_set),
        .consume_i  (consume),
        .wake_clr_i (wfe_clr),
        .flag_o     (flag)
    );

    assign req.wfi        = wfi_stb;
    assign req.wfe        = wfe_stb;
    assign req.exit_sleep = exc_ret_stb & sleep_on_exit_en;

    slpwk_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .irq_wake_i (isum.eligible),
        .evt_wake_i (evt_set),
        .flag_i     (flag),
        .halt_o     (core_halt),
        .wake_o     (wake_stb),
        .skip_o     (wfe_skip_ack),
        .consume_o  (consume),
        .wfe_clr_o  (wfe_clr)
    );

    assign exc_take_ok = isum.eligible & ~int_mask;

    AST_MASK_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
        int_mask |-> !exc_take_ok); // R8
    AST_RUN_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
        wake_stb |=> !core_halt); // R11
    AST_SKIP_NO_HALT: assert property (@(posedge clk) disable iff (rst)
        wfe_skip_ack |=> !core_halt); // R4

endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;

    localparam int N  = 8;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst;
    logic wfi_stb, wfe_stb, sev_stb, exc_ret_stb;
    logic [N-1:0] irq_pend, irq_en;
    logic [N*PW-1:0] irq_prio;
    logic [PW-1:0] cur_prio;
    logic int_mask, sleep_on_exit_en, evt_on_pend_en;
    logic core_halt, wfe_skip_ack, wake_stb, exc_take_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sleep_wake_ctrl #(.NUM_IRQ(N), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst(rst),
        .wfi_stb(wfi_stb), .wfe_stb(wfe_stb), .sev_stb(sev_stb),
        .exc_ret_stb(exc_ret_stb),
        .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio(irq_prio),
        .cur_prio(cur_prio), .int_mask(int_mask),
        .sleep_on_exit_en(sleep_on_exit_en), .evt_on_pend_en(evt_on_pend_en),
        .core_halt(core_halt), .wfe_skip_ack(wfe_skip_ack),
        .wake_stb(wake_stb), .exc_take_ok(exc_take_ok)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    // advance one clock; inputs are then changed just after the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic clear_strobes();
        wfi_stb = 0; wfe_stb = 0; sev_stb = 0; exc_ret_stb = 0;
    endtask

    task automatic t_reset();
        chk("R1 halt after reset", core_halt, 1'b0);
        chk("R1 wake after reset", wake_stb, 1'b0);
        chk("R1 skip after reset", wfe_skip_ack, 1'b0);
        chk("R1 take after reset", exc_take_ok, 1'b0);
        wfe_stb = 1; settle();
        chk("R1 flag clear, no skip", wfe_skip_ack, 1'b0);
        step(); clear_strobes(); settle();
        chk("R1 first wfe sleeps", core_halt, 1'b1);
        sev_stb = 1; settle();
        chk("R5 sev wakes wfe sleep", wake_stb, 1'b1);
        step(); clear_strobes(); settle();
        chk("R11 halt low after wake", core_halt, 1'b0);
        chk("R11 wake one cycle", wake_stb, 1'b0);
    endtask

    task automatic t_wfi();
        wfi_stb = 1; step(); clear_strobes(); settle();
        chk("R2 wfi sleeps", core_halt, 1'b1);
        irq_pend[3] = 1; evt_on_pend_en = 1; settle();
        chk("R7 disabled line with event, no wake", wake_stb, 1'b0);
        step(); settle();
        chk("R7 still halted", core_halt, 1'b1);
        evt_on_pend_en = 0; irq_pend[5] = 1; irq_en[5] = 1; settle();
        chk("R7 equal priority no wake", wake_stb, 1'b0);
        step(); settle();
        chk("R7 still halted equal prio", core_halt, 1'b1);
        irq_pend[2] = 1; irq_en[2] = 1; settle();
        chk("R7 eligible wakes", wake_stb, 1'b1);
        chk("R8 take allowed unmasked", exc_take_ok, 1'b1);
        chk("R11 halt held in wake cycle", core_halt, 1'b1);
        step(); settle();
        chk("R11 running after wake", core_halt, 1'b0);
        chk("R11 wake dropped", wake_stb, 1'b0);
        irq_pend = '0; irq_en = '0; step(); settle();
        // event set during wfi sleep must make next wfe fall through
        wfe_stb = 1; settle();
        chk("R10 flag from wfi-time edge gives skip", wfe_skip_ack, 1'b1);
        step(); clear_strobes(); settle();
        chk("R4 skip keeps core awake", core_halt, 1'b0);
    endtask

    task automatic t_wfi_now();
        irq_pend[2] = 1; irq_en[2] = 1; wfi_stb = 1; step(); clear_strobes(); settle();
        chk("R3 wfi with eligible stays awake", core_halt, 1'b0);
        irq_pend = '0; irq_en = '0; step(); settle();
    endtask

    task automatic t_wfe();
        wfe_stb = 1; settle();
        chk("R4 flag clear no skip", wfe_skip_ack, 1'b0);
        step(); clear_strobes(); settle();
        chk("R4 wfe sleeps", core_halt, 1'b1);
        sev_stb = 1; settle();
        chk("R5 sev wake", wake_stb, 1'b1);
        step(); clear_strobes(); settle();
        chk("R5 awake after sev", core_halt, 1'b0);
        sev_stb = 1; step(); clear_strobes();
        wfe_stb = 1; settle();
        chk("R5 sev then wfe skips", wfe_skip_ack, 1'b1);
        step(); clear_strobes(); settle();
        chk("R4 no sleep on skip", core_halt, 1'b0);
        wfe_stb = 1; settle();
        chk("R4 flag cleared by skip", wfe_skip_ack, 1'b0);
        step(); clear_strobes(); settle();
        chk("R4 second wfe sleeps", core_halt, 1'b1);
        irq_pend[2] = 1; irq_en[2] = 1; settle();
        chk("R9 eligible wakes wfe sleep", wake_stb, 1'b1);
        step(); settle();
        chk("R9 awake", core_halt, 1'b0);
        irq_pend = '0; irq_en = '0; step(); settle();
    endtask

    task automatic t_evt_pend();
        evt_on_pend_en = 1;
        wfe_stb = 1; step(); clear_strobes(); settle();
        chk("R10 wfe sleeps", core_halt, 1'b1);
        irq_pend[3] = 1; settle();
        chk("R10 disabled rising pend wakes", wake_stb, 1'b1);
        step(); settle();
        chk("R10 awake after event", core_halt, 1'b0);
        wfe_stb = 1; settle();
        chk("R10 held pend no new event", wfe_skip_ack, 1'b0);
        step(); clear_strobes(); settle();
        chk("R10 held pend wfe sleeps", core_halt, 1'b1);
        evt_on_pend_en = 0; irq_pend[3] = 0; irq_pend[4] = 1; settle();
        chk("R10 control off no wake", wake_stb, 1'b0);
        step(); settle();
        chk("R10 control off stays asleep", core_halt, 1'b1);
        sev_stb = 1; step(); clear_strobes(); settle();
        chk("R5 sev releases", core_halt, 1'b0);
        irq_pend = '0; step(); settle();
    endtask

    task automatic t_exit();
        exc_ret_stb = 1; step(); clear_strobes(); settle();
        chk("R6 exit with control off stays awake", core_halt, 1'b0);
        sleep_on_exit_en = 1;
        exc_ret_stb = 1; step(); clear_strobes(); settle();
        chk("R6 exit sleeps", core_halt, 1'b1);
        irq_pend[3] = 1; step(); settle();
        chk("R7 exit sleep ignores disabled line", core_halt, 1'b1);
        irq_pend[2] = 1; irq_en[2] = 1; settle();
        chk("R7 exit sleep wake", wake_stb, 1'b1);
        step(); settle();
        chk("R7 exit sleep released", core_halt, 1'b0);
        irq_pend = '0; irq_en = '0; sleep_on_exit_en = 0; step(); settle();
    endtask

    task automatic t_mask();
        int_mask = 1;
        wfi_stb = 1; step(); clear_strobes(); settle();
        chk("R8 masked wfi sleeps", core_halt, 1'b1);
        irq_pend[2] = 1; irq_en[2] = 1; settle();
        chk("R8 masked wake occurs", wake_stb, 1'b1);
        chk("R8 masked no take", exc_take_ok, 1'b0);
        step(); settle();
        chk("R8 awake while masked", core_halt, 1'b0);
        chk("R8 still no take", exc_take_ok, 1'b0);
        int_mask = 0; settle();
        chk("R8 take after unmask", exc_take_ok, 1'b1);
        irq_pend = '0; irq_en = '0; step(); settle();
    endtask

    task automatic t_ignore();
        wfi_stb = 1; step(); clear_strobes(); settle();
        chk("R12 asleep", core_halt, 1'b1);
        sev_stb = 1; step(); clear_strobes();
        wfe_stb = 1; settle();
        chk("R12 wfe ignored asleep, no skip", wfe_skip_ack, 1'b0);
        step(); clear_strobes(); settle();
        chk("R12 wfe no state change", core_halt, 1'b1);
        sleep_on_exit_en = 1; exc_ret_stb = 1; step(); clear_strobes(); settle();
        chk("R12 exit ignored", core_halt, 1'b1);
        irq_pend[2] = 1; irq_en[2] = 1; wfi_stb = 1; settle();
        chk("R12 wake with wfi asserted", wake_stb, 1'b1);
        step(); clear_strobes(); settle();
        chk("R12 awake", core_halt, 1'b0);
        irq_pend = '0; irq_en = '0; sleep_on_exit_en = 0; step(); settle();
        chk("R12 no re-entry", core_halt, 1'b0);
        // the flag set by sev during wfi sleep survives: wfe falls through
        wfe_stb = 1; settle();
        chk("R12 flag kept, wfe skips", wfe_skip_ack, 1'b1);
        step(); clear_strobes(); settle();
    endtask

    initial begin
        rst = 1; clear_strobes();
        irq_pend = '0; irq_en = '0;
        for (int k = 0; k < N; k++) irq_prio[k*PW +: PW] = 3'd6;
        irq_prio[2*PW +: PW] = 3'd1;
        irq_prio[5*PW +: PW] = 3'd4;
        cur_prio = 3'd4;
        int_mask = 0; sleep_on_exit_en = 0; evt_on_pend_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; settle();
        t_reset();
        t_wfi();
        t_wfi_now();
        t_wfe();
        t_evt_pend();
        t_exit();
        t_mask();
        t_ignore();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule